// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR flash and decides when an embedded program or erase operation inside the flash has ended. Once command issue is done elsewhere, the host pulses `start_i` with the address to watch, the byte that was written (for a program) or `8'hFF` (for an erase), and a method select. The poller then issues single-byte reads on a simple request/acknowledge port. It interprets status bit 7 (complement-data polling), bit 6 (toggle detection) and bit 5 (error flag) until it reaches a verdict.

Two detection methods are offered. Complement-data polling compares bit 7 of each read with bit 7 of the expected byte. Toggle detection reads in pairs and looks for bit 6 to stop changing. In both methods, seeing the error flag does not end the run on its own. The error flag and the completion bits may change in the same read, so the poller always rechecks the completion condition before it declares a failure. On failure it can write the reset command byte to the flash. An optional read budget ends a run that never settles with its own timeout verdict.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst_n` is low and after its release, `busy_o`, `done_o`, `bus_req_o` and `bus_we_o` are 0, and `result_o` and `reads_o` are 0.
- R2: A `start_i` seen in idle latches the configuration and starts reads of `addr_i`. `bus_req_o`, `bus_addr_o` and `bus_we_o` hold steady until `bus_ack_i`. A `start_i` seen while busy is ignored, including its address and method.
- R3: With `method_i`=0 (complement-data polling), a read whose bit 7 equals bit 7 of `expect_i` ends the run with `result_o`=1 (pass), whatever bit 5 holds.
- R4: With `method_i`=0, a read whose bit 7 mismatches and whose bit 5 is 0 is followed by another ordinary poll read.
- R5: With `method_i`=0, a read whose bit 7 mismatches and whose bit 5 is 1 is followed by exactly one recheck read. The run passes (1) if that read's bit 7 matches and fails (`result_o`=2) otherwise.
- R6: With `method_i`=1 (toggle), reads go in pairs. If bit 6 is equal in both reads of a pair, the run passes (1).
- R7: With `method_i`=1, when bit 6 differs within a pair and bit 5 of the pair's second read is 0, a new pair of reads follows.
- R8: With `method_i`=1, when bit 6 differs and bit 5 of the second read is 1, one recheck pair follows. The run passes if bit 6 is equal within that pair and fails (2) otherwise.
- R9: On a fail with `rst_on_fail_i` latched as 1, the poller makes one write of byte `8'hF0` to the polled address (`bus_we_o`=1) and completes after its acknowledge. With `rst_on_fail_i` latched as 0, it completes with no write.
- R10: With `tmo_en_i`=1, a read that brings the run's read count to at least `tmo_limit_i` without reaching a verdict ends the run with `result_o`=3 (timeout) and no write. A limit of 0 acts as 1. A verdict on that same read takes priority.
- R11: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the run's last transfer, with `busy_o` low. `result_o` is non-zero from then until the next accepted start.
- R12: `reads_o` is cleared on an accepted start and counts acknowledged reads of the run. It saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| method_i | input | 1 | 0 complement-data polling, 1 toggle detection |
| addr_i | input | ADDR_W | Address to poll |
| expect_i | input | 8 | Expected final byte (bit 7 used by data polling) |
| rst_on_fail_i | input | 1 | Write reset command byte after a fail |
| tmo_en_i | input | 1 | Enable the read budget |
| tmo_limit_i | input | CNT_W | Read budget |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 none, 1 pass, 2 fail, 3 timeout |
| reads_o | output | CNT_W | Reads performed in the current or last run |
| bus_req_o | output | 1 | Transfer request, held until acknowledge |
| bus_we_o | output | 1 | 1 for the reset-command write, 0 for reads |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid with it |
| bus_rdata_i | input | 8 | Read data |

## Verification
A start sampled at a clock edge raises `bus_req_o` after that edge. Each transfer ends at the edge where `bus_req_o` and `bus_ack_i` are both high. The verdict, `done_o`, `result_o` and the final `reads_o` appear after the edge that takes the last acknowledge, and `done_o` falls one edge later. The bench therefore drives inputs and the responder on opposite clock phases and samples outputs 2 ns after each rising edge. It waits for `done_o`, checks the verdict, the read count and any command write in that cycle, and checks the drop of `done_o` and the held result one cycle later. Response latencies of 0 to 2 cycles are swept so that the same verdicts are checked under different acknowledge timing.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  localparam int FLASH_DW   = 8;
  localparam int POLL_BIT   = 7;  // complement-data status bit
  localparam int TOG_BIT    = 6;  // toggling status bit
  localparam int ERR_BIT    = 5;  // time-limit exceeded flag
  localparam logic [FLASH_DW-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_PASS = 2'd1,
    RES_FAIL = 2'd2,
    RES_TMO  = 2'd3
  } fp_result_e;

  typedef enum logic [2:0] {
    PH_DP_POLL  = 3'd0,
    PH_DP_RECHK = 3'd1,
    PH_TG_A     = 3'd2,
    PH_TG_B     = 3'd3,
    PH_TG_RA    = 3'd4,
    PH_TG_RB    = 3'd5
  } fp_phase_e;

  typedef enum logic [1:0] {
    VD_CONT = 2'd0,
    VD_PASS = 2'd1,
    VD_FAIL = 2'd2
  } fp_verdict_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_CMD  = 2'd2
  } fp_seq_e;

endpackage

// File: rtl/fpoll_decide.sv
module fpoll_decide
  import fpoll_pkg::*;
(
  input  fp_phase_e              phase_i,
  input  logic [FLASH_DW-1:0]    byte_i,
  input  logic                   exp_pol_i,
  input  logic                   prev_tog_i,
  output fp_verdict_e            verdict_o,
  output fp_phase_e              next_phase_o
);

  logic pol_match;
  logic tog_same;
  logic err_flag;

  assign pol_match = (byte_i[POLL_BIT] == exp_pol_i);
  assign tog_same  = (byte_i[TOG_BIT] == prev_tog_i);
  assign err_flag  = byte_i[ERR_BIT];

  always_comb begin
    verdict_o    = VD_CONT;
    next_phase_o = phase_i;
    unique case (phase_i)
      PH_DP_POLL: begin
        if (pol_match) begin
          verdict_o = VD_PASS;
        end else if (err_flag) begin
          next_phase_o = PH_DP_RECHK;
        end
      end
      PH_DP_RECHK: begin
        verdict_o = pol_match ? VD_PASS : VD_FAIL;
      end
      PH_TG_A: begin
        next_phase_o = PH_TG_B;
      end
      PH_TG_B: begin
        if (tog_same) begin
          verdict_o = VD_PASS;
        end else if (err_flag) begin
          next_phase_o = PH_TG_RA;
        end else begin
          next_phase_o = PH_TG_A;
        end
      end
      PH_TG_RA: begin
        next_phase_o = PH_TG_RB;
      end
      PH_TG_RB: begin
        verdict_o = tog_same ? VD_PASS : VD_FAIL;
      end
      default: begin
        verdict_o    = VD_FAIL;
        next_phase_o = PH_DP_POLL;
      end
    endcase
  end

endmodule

// File: rtl/fpoll_count.sv
module fpoll_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             tmo_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             limit_hit_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bumped;
  logic [CNT_W-1:0] lim_eff;

  assign bumped  = (cnt_q == CNT_MAX) ? CNT_MAX : (cnt_q + CNT_ONE);
  assign lim_eff = (limit_i == '0) ? CNT_ONE : limit_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = bumped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i || inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o     = cnt_q;
  assign limit_hit_o = tmo_en_i && (bumped >= lim_eff);

  p_count_saturates_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_count_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                method_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [FLASH_DW-1:0] expect_i,
  input  logic                rst_on_fail_i,
  input  logic                tmo_en_i,
  input  logic [CNT_W-1:0]    tmo_limit_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          result_o,
  output logic [CNT_W-1:0]    reads_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [FLASH_DW-1:0] bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic [FLASH_DW-1:0] bus_rdata_i
);

  fp_seq_e     st_q, st_d;
  fp_phase_e   ph_q, ph_d;
  fp_result_e  res_q, res_d;
  logic        done_q, done_d;
  logic        tog_q, tog_d;

  logic [ADDR_W-1:0] addr_q;
  logic              pol_q;
  logic              rof_q;
  logic              ten_q;
  logic [CNT_W-1:0]  lim_q;

  logic        take_start;
  logic        rd_ack;
  logic        cmd_ack;
  logic        limit_hit;
  fp_verdict_e verdict;
  fp_phase_e   nxt_phase;

  assign take_start = (st_q == SQ_IDLE) && start_i;
  assign rd_ack     = (st_q == SQ_READ) && bus_ack_i;
  assign cmd_ack    = (st_q == SQ_CMD) && bus_ack_i;

  fpoll_decide u_decide (
    .phase_i      (ph_q),
    .byte_i       (bus_rdata_i),
    .exp_pol_i    (pol_q),
    .prev_tog_i   (tog_q),
    .verdict_o    (verdict),
    .next_phase_o (nxt_phase)
  );

  fpoll_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (take_start),
    .inc_i       (rd_ack),
    .tmo_en_i    (ten_q),
    .limit_i     (lim_q),
    .count_o     (reads_o),
    .limit_hit_o (limit_hit)
  );

  // configuration capture, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pol_q  <= 1'b0;
      rof_q  <= 1'b0;
      ten_q  <= 1'b0;
      lim_q  <= '0;
    end else if (take_start) begin
      addr_q <= addr_i;
      pol_q  <= expect_i[POLL_BIT];
      rof_q  <= rst_on_fail_i;
      ten_q  <= tmo_en_i;
      lim_q  <= tmo_limit_i;
    end
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    res_d  = res_q;
    tog_d  = tog_q;
    done_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d  = SQ_READ;
          ph_d  = method_i ? PH_TG_A : PH_DP_POLL;
          res_d = RES_NONE;
        end
      end
      SQ_READ: begin
        if (bus_ack_i) begin
          tog_d = bus_rdata_i[TOG_BIT];
          unique case (verdict)
            VD_PASS: begin
              st_d   = SQ_IDLE;
              res_d  = RES_PASS;
              done_d = 1'b1;
            end
            VD_FAIL: begin
              if (rof_q) begin
                st_d = SQ_CMD;
              end else begin
                st_d   = SQ_IDLE;
                res_d  = RES_FAIL;
                done_d = 1'b1;
              end
            end
            default: begin
              if (limit_hit) begin
                st_d   = SQ_IDLE;
                res_d  = RES_TMO;
                done_d = 1'b1;
              end else begin
                ph_d = nxt_phase;
              end
            end
          endcase
        end
      end
      SQ_CMD: begin
        if (bus_ack_i) begin
          st_d   = SQ_IDLE;
          res_d  = RES_FAIL;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d = SQ_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= PH_DP_POLL;
      res_q  <= RES_NONE;
      tog_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      res_q  <= res_d;
      tog_q  <= tog_d;
      done_q <= done_d;
    end
  end

  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign bus_req_o   = (st_q != SQ_IDLE);
  assign bus_we_o    = (st_q == SQ_CMD);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = (st_q == SQ_CMD) ? RESET_CMD : '0;

  p_hold_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_addr_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_has_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != RES_NONE && !busy_o));

  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_req_o && bus_ack_i));

  p_write_means_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(bus_we_o)) |-> (result_o == RES_FAIL));

  p_timeout_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_TMO) |-> (ten_q && !$past(bus_we_o)));

endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
  localparam int AW = 19;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          start_i, method_i, rst_on_fail_i, tmo_en_i;
  logic [AW-1:0] addr_i;
  logic [7:0]    expect_i;
  logic [CW-1:0] tmo_limit_i;
  logic          busy_o, done_o, bus_req_o, bus_we_o;
  logic [1:0]    result_o;
  logic [CW-1:0] reads_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic          ack;
  logic [7:0]    rdata;

  flash_done_poller #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .method_i(method_i),
    .addr_i(addr_i), .expect_i(expect_i), .rst_on_fail_i(rst_on_fail_i),
    .tmo_en_i(tmo_en_i), .tmo_limit_i(tmo_limit_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .reads_o(reads_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  int checks = 0;
  int errors = 0;

  // scripted flash responses
  logic [7:0]    scr [8];
  int            pass_after;
  logic          cfg_meth;
  logic          cfg_e7;
  int            lat;
  int            rd_served, wr_seen, addr_bad, wait_c;
  logic [AW-1:0] cur_addr, wr_addr;
  logic [7:0]    wr_data;

  function automatic logic [7:0] byte_at(input int i);
    logic [7:0] b;
    if (i < 8) b = scr[i];
    else if (i < pass_after) b = cfg_meth ? {1'b0, (i % 2 == 1), 6'h00} : {~cfg_e7, 7'h00};
    else b = cfg_meth ? 8'h00 : {cfg_e7, 7'h00};
    return b;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; wait_c = 0; rdata = 8'h00;
    end else if (ack) begin
      ack = 1'b0; wait_c = 0;
    end else if (bus_req_o) begin
      if (wait_c >= lat) begin
        ack = 1'b1;
        if (bus_we_o) begin
          wr_seen++; wr_addr = bus_addr_o; wr_data = bus_wdata_o;
        end else begin
          rdata = byte_at(rd_served);
          if (bus_addr_o != cur_addr) addr_bad++;
          rd_served++;
        end
      end else begin
        wait_c++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // verdict model taken from the requirements (1 pass, 2 fail, 3 timeout)
  task automatic model(input logic meth, input logic e7, input logic ten, input int lim,
                       output int res, output int nrd);
    int leff, ph, v;
    logic prev;
    logic [7:0] b;
    leff = (lim == 0) ? 1 : lim;
    ph = 0; prev = 1'b0; res = 0; nrd = 0;
    while (res == 0 && nrd < 5000) begin
      b = byte_at(nrd);
      nrd++;
      v = 0;
      if (!meth) begin
        if (ph == 0) begin
          if (b[7] == e7) v = 1;
          else if (b[5]) ph = 1;
        end else begin
          v = (b[7] == e7) ? 1 : 2;
        end
      end else begin
        case (ph)
          0: begin prev = b[6]; ph = 1; end
          1: begin
            if (b[6] == prev) v = 1;
            else if (b[5]) ph = 2;
            else ph = 0;
          end
          2: begin prev = b[6]; ph = 3; end
          default: v = (b[6] == prev) ? 1 : 2;
        endcase
      end
      if (v != 0) res = v;
      else if (ten && nrd >= leff) res = 3;
    end
  endtask

  task automatic run_one(input logic meth, input logic [7:0] ebyte, input logic [AW-1:0] addr,
                         input logic rof, input logic ten, input int lim, input int lt,
                         input bit poke, input string vtag);
    int eres, enrd, n, ewr, erd;
    cfg_meth = meth;
    cfg_e7   = ebyte[7];
    model(meth, ebyte[7], ten, lim, eres, enrd);
    ewr = (eres == 2 && rof) ? 1 : 0;
    erd = (enrd > 255) ? 255 : enrd;
    @(posedge clk); #2;
    rd_served = 0; wr_seen = 0; addr_bad = 0; cur_addr = addr; lat = lt;
    start_i = 1'b1; method_i = meth; addr_i = addr; expect_i = ebyte;
    rst_on_fail_i = rof; tmo_en_i = ten; tmo_limit_i = CW'(lim);
    @(posedge clk); #2;
    start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1; addr_i = addr ^ 1; method_i = ~meth;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 4000) begin
      @(posedge clk); #2;
      n++;
    end
    chk(done_o == 1'b1, "R11 done pulse", int'(done_o), 1);
    chk(int'(result_o) == eres, vtag, int'(result_o), eres);
    chk(int'(reads_o) == erd, "R12 R4 R7 reads_o", int'(reads_o), erd);
    chk(rd_served == enrd, "R4 R5 R7 R8 reads issued", rd_served, enrd);
    chk(wr_seen == ewr, "R9 reset write count", wr_seen, ewr);
    if (ewr == 1) begin
      chk(wr_addr == addr, "R9 reset write address", int'(wr_addr), int'(addr));
      chk(wr_data == 8'hF0, "R9 reset write data", int'(wr_data), 240);
    end
    chk(addr_bad == 0, "R2 polled address fixed", addr_bad, 0);
    chk(busy_o == 1'b0, "R11 busy low at done", int'(busy_o), 0);
    @(posedge clk); #2;
    chk(done_o == 1'b0, "R11 done one cycle", int'(done_o), 0);
    chk(int'(result_o) == eres, "R11 result held", int'(result_o), eres);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] eb;
    logic [1:0] s;
    rst_n = 1'b0; start_i = 1'b0; method_i = 1'b0; addr_i = '0; expect_i = 8'h00;
    rst_on_fail_i = 1'b0; tmo_en_i = 1'b0; tmo_limit_i = '0;
    lat = 0; pass_after = 8; cfg_meth = 1'b0; cfg_e7 = 1'b0;
    rd_served = 0; wr_seen = 0; addr_bad = 0; cur_addr = '0;
    for (int k = 0; k < 8; k++) scr[k] = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk({busy_o, done_o, bus_req_o, bus_we_o} == 4'b0000, "R1 control in reset",
        int'({busy_o, done_o, bus_req_o, bus_we_o}), 0);
    chk(result_o == 2'd0 && reads_o == '0, "R1 status in reset", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk({busy_o, done_o, bus_req_o, bus_we_o} == 4'b0000, "R1 control after reset",
        int'({busy_o, done_o, bus_req_o, bus_we_o}), 0);
    chk(result_o == 2'd0 && reads_o == '0, "R1 status after reset", int'(result_o), 0);

    // sweep all 4-read status scripts for both methods
    for (int m = 0; m < 2; m++) begin
      for (int code = 0; code < 256; code++) begin
        eb = 8'((code * 3) + (m * 91));
        for (int k = 0; k < 4; k++) begin
          s = 2'((code >> (2 * k)) & 3);
          if (m == 0) scr[k] = {s[1] ? eb[7] : ~eb[7], k[0], s[0], 5'h0A};
          else        scr[k] = {k[0], s[1], s[0], 5'h05};
        end
        for (int k = 4; k < 8; k++) scr[k] = (m == 0) ? {eb[7], 7'h00} : 8'h00;
        pass_after = 8;
        run_one(m[0], eb, AW'(code * 977 + m), code[0] ^ code[3], (code % 4) == 3,
                code % 7, code % 3, ((code % 3) == 2) && code[4],
                (m == 0) ? "R3 R5 R10 data verdict" : "R6 R8 R10 toggle verdict");
      end
    end

    // budget exhaustion with no verdict, both methods
    for (int m = 0; m < 2; m++) begin
      for (int lim = 0; lim < 7; lim++) begin
        for (int k = 0; k < 8; k++) scr[k] = (m == 0) ? 8'h00 : {1'b0, k[0], 6'h00};
        pass_after = 1000;
        run_one(m[0], 8'h80, AW'(lim + 40), 1'b1, 1'b1, lim, lim % 2, 1'b0, "R10 timeout");
      end
    end

    // verdict on the limit read wins over the timeout
    scr[0] = 8'h00; scr[1] = 8'h20; scr[2] = 8'h80;
    for (int k = 3; k < 8; k++) scr[k] = 8'h00;
    pass_after = 8;
    run_one(1'b0, 8'hFF, AW'(5), 1'b1, 1'b1, 3, 0, 1'b0, "R10 R5 verdict beats limit");

    // long run: counter saturation, then a budget of the full count
    for (int k = 0; k < 8; k++) scr[k] = 8'h00;
    pass_after = 300;
    run_one(1'b0, 8'h80, AW'(77), 1'b0, 1'b0, 0, 0, 1'b0, "R12 R3 saturating count");
    pass_after = 1000;
    run_one(1'b0, 8'h80, AW'(78), 1'b0, 1'b1, 255, 0, 1'b0, "R10 R12 full budget");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule